// File: doc/BRIEF.md
# XCBC-MAC Message Authentication Sequencer

This block computes an AES XCBC-MAC over a message made of 16-byte blocks. It has no cipher rounds of its own. It drives an external 128-bit block-cipher engine through a request/response port and handles everything around that engine: deriving the three subkeys from the user key, chaining the blocks, padding a short final block, and choosing the subkey that is folded into the final block. The encryption direction plays no part, so the block has no direction input.

All state lives in a small register file with two banks of 64-bit words: a key bank and a context bank. Software loads a segment's keys and context through a write port and can read the context bank back. This lets a long message be split into segments. A segment run with the suspend flag leaves the running chain value in the context. Software can save that state and later restore it, then continue the message. A segment run with the preload flag uses subkeys that software has already placed in the registers. With the compare flag set, the final MAC is checked against a received tag.

To run a segment, software pulses `start` with the mode flags applied. It then streams blocks on the message port and waits for `done`. Every block except the last of the whole message must carry 16 bytes.

Top module: `xcbc_mac_seq`

## Requirements
- R1: With the preload flag clear, each segment begins with three cipher requests under the key held in key-bank words 1 (bits 127:64) and 2. The plaintexts are the byte 0x01, 0x02 and 0x03, each repeated 16 times. The results are stored as K1 in context words 5–6, K2 in words 7–8 and K3 in words 9–10, with the lower word number holding the upper half.
- R2: Each message block is encrypted under K1 after being XORed with the chain value held in context words 1–2. The result replaces that chain value, so a message starting from a zero chain follows CBC with a zero IV.
- R3: When the final block of the message carries 16 bytes (`msg_bytes` = 16), it is also XORed with K2 before encryption.
- R4: When the final block carries 0 to 15 bytes, the valid bytes are taken left-aligned from bit 127 downward. The byte 0x80 follows them, the remaining bytes are zero, and the padded block is XORed with K3. Data bytes past the count have no effect.
- R5: With the suspend flag set, the last block of the segment receives no subkey XOR and the chain value stays in context words 1–2. A message split into a suspended segment and a final segment gives the same MAC as the same message run unsplit.
- R6: With the preload flag set, no derivation requests are issued. K1 is taken from key-bank words 5–6, and K2 and K3 from context words 7–10.
- R7: With the compare flag set and the suspend flag clear, `icv_fail` is high in the `done` cycle exactly when the MAC differs in any bit from context words 3–4. In every other case `icv_fail` stays low.
- R8: Context word 11 adds 8 × `msg_bytes` for every accepted block across segments. Context word 0 is cleared at `start` and adds the same amount within the segment. Addresses 12 and above read as zero and ignore writes.
- R9: The block has at most one cipher request outstanding. A request keeps valid, key and block stable until it is accepted. No new request is issued before the response arrives, and `msg_ready` is never high together with `ci_req_valid`.
- R10: `done` is a one-cycle pulse in the cycle after the response for the segment's last block. In that cycle `mac` equals context words 1–2.
- R11: Reset clears both register banks, the counters and the sequencer. `done`, `msg_ready`, `ci_req_valid` and `mac` are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a segment; mode flags sampled with it |
| mode_suspend | input | 1 | Segment is not the end of the message; no final subkey XOR |
| mode_preload | input | 1 | Use preloaded subkeys instead of deriving them |
| mode_icv | input | 1 | Compare the final MAC with the received tag |
| reg_we | input | 1 | Register write strobe |
| reg_bank | input | 1 | 0 selects the context bank, 1 the key bank |
| reg_addr | input | 4 | Word address for the write |
| reg_wdata | input | 64 | Write data |
| ctx_rd_addr | input | 4 | Context-bank read address |
| ctx_rd_data | output | 64 | Context-bank read data |
| msg_valid | input | 1 | Message block valid |
| msg_ready | output | 1 | Sequencer accepts a message block |
| msg_data | input | 128 | Message block, first byte in bits 127:120 |
| msg_last | input | 1 | Block is the last of this segment |
| msg_bytes | input | 5 | Valid bytes in the block (16 unless final) |
| ci_req_valid | output | 1 | Cipher request valid |
| ci_req_ready | input | 1 | Cipher engine accepts request |
| ci_key | output | 128 | Key for the request |
| ci_block | output | 128 | Plaintext for the request |
| ci_rsp_valid | input | 1 | Cipher result valid |
| ci_rsp_data | input | 128 | Cipher result |
| done | output | 1 | Segment finished (one cycle) |
| mac | output | 128 | Current chain value / final MAC |
| icv_fail | output | 1 | Tag mismatch, meaningful with done |

## Verification
The cycle that accepts the final block does two things at once. It picks K2 or K3 from the byte count, and it adds that same count to both length counters. The bench drives final blocks of 16, 5 and 0 bytes and judges each one twice: by the MAC compared against an independent model, and by reading back the segment and total length words. The tag compare also falls in the same cycle as `done`. Matching, single-bit-mismatched and suspended-segment tags show that the verdict is taken from the freshly written chain value.

// File: rtl/xcbc_pkg.sv
package xcbc_pkg;

  // sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KREQ,
    ST_KWAIT,
    ST_MSG,
    ST_BREQ,
    ST_BWAIT,
    ST_FIN
  } seq_state_t;

  typedef struct packed {
    logic suspend;
    logic preload;
    logic icv;
  } seg_mode_t;

  // context bank word map (pairs: lower word number = upper half)
  localparam int CX_SEGLEN = 0;
  localparam int CX_CHAIN  = 1;
  localparam int CX_TAG    = 3;
  localparam int CX_K1     = 5;
  localparam int CX_K2     = 7;
  localparam int CX_K3     = 9;
  localparam int CX_TOTLEN = 11;
  // key bank word map
  localparam int KB_KEY    = 1;
  localparam int KB_K1     = 5;

endpackage

// File: rtl/xcbc_ctx_regs.sv
module xcbc_ctx_regs
  import xcbc_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 4,
  parameter int NREG   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic                  host_bank,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [WORD_W-1:0]     host_wdata,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [WORD_W-1:0]     rd_data,
  input  logic                  eng_we,
  input  logic [ADDR_W-1:0]     eng_idx,
  input  logic [2*WORD_W-1:0]   eng_data,
  input  logic                  seg_clr,
  input  logic                  len_add_en,
  input  logic [WORD_W-1:0]     len_add,
  output logic [2*WORD_W-1:0]   chain,
  output logic [2*WORD_W-1:0]   tag,
  output logic [2*WORD_W-1:0]   k1_ctx,
  output logic [2*WORD_W-1:0]   k2,
  output logic [2*WORD_W-1:0]   k3,
  output logic [2*WORD_W-1:0]   user_key,
  output logic [2*WORD_W-1:0]   k1_pre
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] ctx_q [DEPTH];
  logic [WORD_W-1:0] key_q [DEPTH];
  logic [ADDR_W-1:0] eng_idx_lo;
  logic              host_in_range;

  assign eng_idx_lo    = eng_idx + 1'b1;
  assign host_in_range = (32'(host_addr) < NREG);

  // context bank: host writes first, engine updates win on the same word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctx_q[i] <= '0;
    end else begin
      if (host_we && !host_bank && host_in_range) ctx_q[host_addr] <= host_wdata;
      if (seg_clr) ctx_q[CX_SEGLEN] <= '0;
      if (len_add_en) begin
        ctx_q[CX_SEGLEN] <= ctx_q[CX_SEGLEN] + len_add;
        ctx_q[CX_TOTLEN] <= ctx_q[CX_TOTLEN] + len_add;
      end
      if (eng_we) begin
        ctx_q[eng_idx]    <= eng_data[2*WORD_W-1:WORD_W];
        ctx_q[eng_idx_lo] <= eng_data[WORD_W-1:0];
      end
    end
  end

  // key bank: host only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) key_q[i] <= '0;
    end else if (host_we && host_bank && host_in_range) begin
      key_q[host_addr] <= host_wdata;
    end
  end

  assign rd_data  = (32'(rd_addr) < NREG) ? ctx_q[rd_addr] : '0;
  assign chain    = {ctx_q[CX_CHAIN], ctx_q[CX_CHAIN+1]};
  assign tag      = {ctx_q[CX_TAG],   ctx_q[CX_TAG+1]};
  assign k1_ctx   = {ctx_q[CX_K1],    ctx_q[CX_K1+1]};
  assign k2       = {ctx_q[CX_K2],    ctx_q[CX_K2+1]};
  assign k3       = {ctx_q[CX_K3],    ctx_q[CX_K3+1]};
  assign user_key = {key_q[KB_KEY],   key_q[KB_KEY+1]};
  assign k1_pre   = {key_q[KB_K1],    key_q[KB_K1+1]};

  // segment length restarts from zero at every start
  assert_seg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seg_clr |=> (ctx_q[CX_SEGLEN] == '0));

endmodule

// File: rtl/xcbc_block_prep.sv
module xcbc_block_prep #(
  parameter int BLK_W = 128,
  parameter int CNT_W = 5
) (
  input  logic [BLK_W-1:0] data,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [BLK_W-1:0] chain,
  input  logic [BLK_W-1:0] k2,
  input  logic [BLK_W-1:0] k3,
  input  logic             apply_sub,
  output logic [BLK_W-1:0] operand
);

  localparam int NB = BLK_W / 8;

  logic [BLK_W-1:0] padded;
  logic [BLK_W-1:0] subkey;
  logic             full_blk;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [CNT_W-1:0] POS = CNT_W'(b);
    assign padded[BLK_W-1-8*b -: 8] =
      (POS < nbytes)  ? data[BLK_W-1-8*b -: 8] :
      (POS == nbytes) ? 8'h80 : 8'h00;
  end

  assign full_blk = (nbytes == CNT_W'(NB));
  assign subkey   = !apply_sub ? '0 : (full_blk ? k2 : k3);
  assign operand  = padded ^ chain ^ subkey;

endmodule

// File: rtl/xcbc_ctrl.sv
module xcbc_ctrl
  import xcbc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  seg_mode_t         mode_in,
  input  logic              msg_valid,
  input  logic              msg_last,
  input  logic              ci_req_ready,
  input  logic              ci_rsp_valid,
  output seg_mode_t         mode_q,
  output logic [1:0]        kidx,
  output logic              key_phase,
  output logic              msg_ready,
  output logic              ci_req_valid,
  output logic              op_load,
  output logic              seg_clr,
  output logic              eng_we,
  output logic [ADDR_W-1:0] eng_idx,
  output logic              done
);

  seq_state_t state_q, state_d;
  seg_mode_t  mode_d;
  logic [1:0] kidx_q, kidx_d;
  logic       last_q, last_d;

  always_comb begin
    state_d      = state_q;
    mode_d       = mode_q;
    kidx_d       = kidx_q;
    last_d       = last_q;
    msg_ready    = 1'b0;
    ci_req_valid = 1'b0;
    op_load      = 1'b0;
    seg_clr      = 1'b0;
    eng_we       = 1'b0;
    eng_idx      = ADDR_W'(CX_CHAIN);
    done         = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          seg_clr = 1'b1;
          mode_d  = mode_in;
          kidx_d  = 2'd1;
          state_d = mode_in.preload ? ST_MSG : ST_KREQ;
        end
      end
      ST_KREQ: begin
        ci_req_valid = 1'b1;
        if (ci_req_ready) state_d = ST_KWAIT;
      end
      ST_KWAIT: begin
        if (ci_rsp_valid) begin
          eng_we  = 1'b1;
          eng_idx = ADDR_W'({kidx_q, 1'b0}) + ADDR_W'(3);
          if (kidx_q == 2'd3) begin
            state_d = ST_MSG;
          end else begin
            kidx_d  = kidx_q + 2'd1;
            state_d = ST_KREQ;
          end
        end
      end
      ST_MSG: begin
        msg_ready = 1'b1;
        if (msg_valid) begin
          op_load = 1'b1;
          last_d  = msg_last;
          state_d = ST_BREQ;
        end
      end
      ST_BREQ: begin
        ci_req_valid = 1'b1;
        if (ci_req_ready) state_d = ST_BWAIT;
      end
      ST_BWAIT: begin
        if (ci_rsp_valid) begin
          eng_we  = 1'b1;
          eng_idx = ADDR_W'(CX_CHAIN);
          state_d = last_q ? ST_FIN : ST_MSG;
        end
      end
      ST_FIN: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      kidx_q  <= 2'd1;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      kidx_q  <= kidx_d;
      last_q  <= last_d;
    end
  end

  assign kidx      = kidx_q;
  assign key_phase = (state_q == ST_KREQ);

  // a response never meets a pending request: one encryption in flight
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ci_rsp_valid |-> !ci_req_valid);

  assert_ready_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_ready && ci_req_valid));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/xcbc_mac_seq.sv
module xcbc_mac_seq
  import xcbc_pkg::*;
#(
  parameter int BLK_W  = 128,
  parameter int ADDR_W = 4,
  parameter int NREG   = 12,
  parameter int CNT_W  = $clog2(BLK_W/8 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode_suspend,
  input  logic               mode_preload,
  input  logic               mode_icv,
  input  logic               reg_we,
  input  logic               reg_bank,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [BLK_W/2-1:0] reg_wdata,
  input  logic [ADDR_W-1:0]  ctx_rd_addr,
  output logic [BLK_W/2-1:0] ctx_rd_data,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [BLK_W-1:0]   msg_data,
  input  logic               msg_last,
  input  logic [CNT_W-1:0]   msg_bytes,
  output logic               ci_req_valid,
  input  logic               ci_req_ready,
  output logic [BLK_W-1:0]   ci_key,
  output logic [BLK_W-1:0]   ci_block,
  input  logic               ci_rsp_valid,
  input  logic [BLK_W-1:0]   ci_rsp_data,
  output logic               done,
  output logic [BLK_W-1:0]   mac,
  output logic               icv_fail
);

  localparam int WORD_W = BLK_W / 2;
  localparam int NB     = BLK_W / 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  seg_mode_t         mode_in, mode_q;
  logic [1:0]        kidx;
  logic              key_phase, op_load, seg_clr, eng_we;
  logic [ADDR_W-1:0] eng_idx;
  logic [BLK_W-1:0]  chain, tag, k1_ctx, k2, k3, user_key, k1_pre;
  logic [BLK_W-1:0]  op_d, op_q;
  logic [WORD_W-1:0] len_add;
  logic              apply_sub;

  assign mode_in = '{suspend: mode_suspend, preload: mode_preload, icv: mode_icv};

  xcbc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start        (start),
    .mode_in      (mode_in),
    .msg_valid    (msg_valid),
    .msg_last     (msg_last),
    .ci_req_ready (ci_req_ready),
    .ci_rsp_valid (ci_rsp_valid),
    .mode_q       (mode_q),
    .kidx         (kidx),
    .key_phase    (key_phase),
    .msg_ready    (msg_ready),
    .ci_req_valid (ci_req_valid),
    .op_load      (op_load),
    .seg_clr      (seg_clr),
    .eng_we       (eng_we),
    .eng_idx      (eng_idx),
    .done         (done)
  );

  assign len_add = WORD_W'({msg_bytes, 3'b000});

  xcbc_ctx_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .host_we    (reg_we),
    .host_bank  (reg_bank),
    .host_addr  (reg_addr),
    .host_wdata (reg_wdata),
    .rd_addr    (ctx_rd_addr),
    .rd_data    (ctx_rd_data),
    .eng_we     (eng_we),
    .eng_idx    (eng_idx),
    .eng_data   (ci_rsp_data),
    .seg_clr    (seg_clr),
    .len_add_en (op_load),
    .len_add    (len_add),
    .chain      (chain),
    .tag        (tag),
    .k1_ctx     (k1_ctx),
    .k2         (k2),
    .k3         (k3),
    .user_key   (user_key),
    .k1_pre     (k1_pre)
  );

  assign apply_sub = msg_last && !mode_q.suspend;

  xcbc_block_prep #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_prep (
    .data      (msg_data),
    .nbytes    (msg_bytes),
    .chain     (chain),
    .k2        (k2),
    .k3        (k3),
    .apply_sub (apply_sub),
    .operand   (op_d)
  );

  // cipher operand held in a register while the request waits
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  op_q <= '0;
    else if (op_load) op_q <= op_d;
  end

  assign ci_block = key_phase ? {NB{{6'b0, kidx}}} : op_q;
  assign ci_key   = key_phase ? user_key : (mode_q.preload ? k1_pre : k1_ctx);
  assign mac      = chain;
  assign icv_fail = done && mode_q.icv && !mode_q.suspend && (chain != tag);

  assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ci_req_valid && !ci_req_ready) |=> (ci_req_valid && $stable(ci_block) && $stable(ci_key)));

  assert_fail_with_done_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    icv_fail |-> done);

endmodule

// File: tb/xcbc_mac_seq_test.sv
module xcbc_mac_seq_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, mode_suspend, mode_preload, mode_icv;
  logic         reg_we, reg_bank;
  logic [3:0]   reg_addr, ctx_rd_addr;
  logic [63:0]  reg_wdata, ctx_rd_data;
  logic         msg_valid, msg_ready, msg_last;
  logic [127:0] msg_data;
  logic [4:0]   msg_bytes;
  logic         ci_req_valid, ci_req_ready, ci_rsp_valid;
  logic [127:0] ci_key, ci_block, ci_rsp_data;
  logic         done, icv_fail;
  logic [127:0] mac;

  always #2.5 clk = ~clk;

  xcbc_mac_seq uut (.*);

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [127:0] mac;
    logic         fail;
    string        req;
  } exp_t;
  exp_t sb[$];

  // stand-in cipher: keyed mixing function, same in engine and model
  function automatic logic [127:0] toy_enc(logic [127:0] k, logic [127:0] x);
    logic [127:0] r;
    r = {x[100:0], x[127:101]} ^ k;
    r = {r[127:64] + r[63:0], r[63:0] ^ k[127:64]};
    r = {r[90:0], r[127:91]} ^ {k[63:0], k[127:64]};
    return r;
  endfunction

  function automatic logic [127:0] derive(logic [127:0] k, int idx);
    logic [127:0] c;
    for (int b = 0; b < 16; b++) c[127-8*b -: 8] = 8'(idx);
    return toy_enc(k, c);
  endfunction

  function automatic logic [127:0] pad_blk(logic [127:0] d, int nb);
    logic [127:0] r;
    for (int b = 0; b < 16; b++)
      r[127-8*b -: 8] = (b < nb) ? d[127-8*b -: 8] : ((b == nb) ? 8'h80 : 8'h00);
    return r;
  endfunction

  logic [127:0] blk [0:7];

  function automatic logic [127:0] model_seg(logic [127:0] c0, logic [127:0] k1,
      logic [127:0] k2, logic [127:0] k3, int n, int lastb, bit susp);
    logic [127:0] c, x;
    c = c0;
    for (int i = 0; i < n; i++) begin
      x = (i == n-1) ? pad_blk(blk[i], lastb) : blk[i];
      x = x ^ c;
      if (i == n-1 && !susp) x = x ^ ((lastb == 16) ? k2 : k3);
      c = toy_enc(k1, x);
    end
    return c;
  endfunction

  // cipher engine model: stalls on ready, variable latency
  logic [7:0]   tick_q;
  logic         busy_q;
  logic [1:0]   lat_q;
  logic [127:0] pend_q;
  int           req_cnt;

  assign ci_req_ready = !busy_q && (tick_q[1:0] != 2'd3);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0; busy_q <= 1'b0; lat_q <= '0; pend_q <= '0;
      ci_rsp_valid <= 1'b0; ci_rsp_data <= '0; req_cnt <= 0;
    end else begin
      tick_q <= tick_q + 8'd1;
      ci_rsp_valid <= 1'b0;
      if (ci_req_valid && ci_req_ready) begin
        busy_q  <= 1'b1;
        pend_q  <= toy_enc(ci_key, ci_block);
        lat_q   <= tick_q[3:2];
        req_cnt <= req_cnt + 1;
      end else if (busy_q) begin
        if (lat_q == 2'd0) begin
          ci_rsp_valid <= 1'b1;
          ci_rsp_data  <= pend_q;
          busy_q       <= 1'b0;
        end else begin
          lat_q <= lat_q - 2'd1;
        end
      end
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each done
  always @(negedge clk) begin
    if (done) begin
      if (sb.size() == 0) begin
        chk("R10 unexpected done", 128'd1, 128'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " mac"}, mac, e.mac);
        chk({e.req, " icv_fail"}, {127'd0, icv_fail}, {127'd0, e.fail});
      end
    end
  end

  // bench model of register contents
  logic [127:0] m_key, m_kpre, m_k1c, m_k2, m_k3, m_chain, m_tag;
  logic [63:0]  m_tot, m_seg;

  task automatic wr(bit bank, int a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_bank = bank; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [63:0] d);
    @(negedge clk);
    ctx_rd_addr = 4'(a);
    #1 d = ctx_rd_data;
  endtask

  task automatic rd_pair(int a, output logic [127:0] d);
    logic [63:0] hi, lo;
    rd(a, hi);
    rd(a + 1, lo);
    d = {hi, lo};
  endtask

  task automatic new_msg();
    wr(1'b0, 1, 64'd0);
    wr(1'b0, 2, 64'd0);
    m_chain = '0;
  endtask

  task automatic fill(int seed);
    for (int i = 0; i < 8; i++)
      blk[i] = {32'(seed * 7919 + i), 32'hA5C3_0000 ^ 32'(i * 131),
                32'(seed) ^ 32'h1234_5678, 32'(i + seed * 3)};
  endtask

  task automatic run_seg(int n, int lastb, bit susp, bit pre, bit icv, string req);
    logic [127:0] k1, k2, k3;
    exp_t e;
    int base;
    if (pre) begin
      k1 = m_kpre; k2 = m_k2; k3 = m_k3;
    end else begin
      k1 = derive(m_key, 1); k2 = derive(m_key, 2); k3 = derive(m_key, 3);
      m_k1c = k1; m_k2 = k2; m_k3 = k3;
    end
    m_chain = model_seg(m_chain, k1, k2, k3, n, lastb, susp);
    e.mac  = m_chain;
    e.fail = icv && !susp && (m_chain != m_tag);
    e.req  = req;
    sb.push_back(e);
    m_seg = 64'(128 * (n - 1) + 8 * lastb);
    m_tot = m_tot + m_seg;
    @(negedge clk);
    base = req_cnt;
    start = 1'b1; mode_suspend = susp; mode_preload = pre; mode_icv = icv;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      msg_valid = 1'b1;
      msg_data  = blk[i];
      msg_last  = (i == n - 1);
      msg_bytes = (i == n - 1) ? 5'(lastb) : 5'd16;
      while (!msg_ready) @(negedge clk);
      @(negedge clk);
    end
    msg_valid = 1'b0;
    msg_last  = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({req, " R9 request count"}, 128'(req_cnt - base), 128'((pre ? 0 : 3) + n));
  endtask

  initial begin
    logic [63:0]  w;
    logic [127:0] p;
    rst_n = 1'b0; start = 1'b0; mode_suspend = 1'b0; mode_preload = 1'b0; mode_icv = 1'b0;
    reg_we = 1'b0; reg_bank = 1'b0; reg_addr = '0; reg_wdata = '0; ctx_rd_addr = '0;
    msg_valid = 1'b0; msg_data = '0; msg_last = 1'b0; msg_bytes = '0;
    m_key = '0; m_kpre = '0; m_k1c = '0; m_k2 = '0; m_k3 = '0; m_chain = '0; m_tag = '0;
    m_tot = '0; m_seg = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11 done", {127'd0, done}, 128'd0);
    chk("R11 msg_ready", {127'd0, msg_ready}, 128'd0);
    chk("R11 ci_req_valid", {127'd0, ci_req_valid}, 128'd0);
    chk("R11 mac", mac, 128'd0);
    rd(11, w); chk("R11 total length", 128'(w), 128'd0);

    // R1/R3: derived keys, full final block
    m_key = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    wr(1'b1, 1, m_key[127:64]);
    wr(1'b1, 2, m_key[63:0]);
    fill(1);
    run_seg(3, 16, 1'b0, 1'b0, 1'b0, "R3");
    rd_pair(5, p);  chk("R1 K1 in context", p, derive(m_key, 1));
    rd_pair(7, p);  chk("R1 K2 in context", p, derive(m_key, 2));
    rd_pair(9, p);  chk("R1 K3 in context", p, derive(m_key, 3));
    rd_pair(1, p);  chk("R2 chain in context", p, m_chain);

    // R4/R8: short final block, length counters
    new_msg();
    fill(2);
    run_seg(2, 5, 1'b0, 1'b0, 1'b0, "R4 five bytes");
    rd(0, w);  chk("R8 segment length", 128'(w), 128'(m_seg));
    rd(11, w); chk("R8 total length", 128'(w), 128'(m_tot));

    // R4: empty message
    new_msg();
    fill(3);
    run_seg(1, 0, 1'b0, 1'b0, 1'b0, "R4 empty");
    rd(0, w);  chk("R8 segment length empty", 128'(w), 128'd0);

    // R5/R6: suspend, save context, resume with preloaded K1
    new_msg();
    fill(4);
    begin
      logic [127:0] whole;
      whole = model_seg(128'd0, derive(m_key, 1), derive(m_key, 2), derive(m_key, 3), 4, 9, 1'b0);
      blk[0] = blk[0];
      run_seg(2, 16, 1'b1, 1'b0, 1'b1, "R5 suspended");
      rd_pair(1, p); chk("R5 chain kept", p, m_chain);
      wr(1'b1, 5, m_k1c[127:64]);
      wr(1'b1, 6, m_k1c[63:0]);
      m_kpre = m_k1c;
      blk[0] = blk[2]; blk[1] = blk[3];
      run_seg(2, 9, 1'b0, 1'b1, 1'b0, "R5 resumed");
      chk("R5 split equals unsplit", m_chain, whole);
    end

    // R6: preload with unrelated subkeys
    new_msg();
    fill(5);
    m_kpre = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    m_k2   = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
    m_k3   = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    wr(1'b1, 5, m_kpre[127:64]); wr(1'b1, 6, m_kpre[63:0]);
    wr(1'b0, 7, m_k2[127:64]);   wr(1'b0, 8, m_k2[63:0]);
    wr(1'b0, 9, m_k3[127:64]);   wr(1'b0, 10, m_k3[63:0]);
    run_seg(2, 16, 1'b0, 1'b1, 1'b0, "R6 full");
    new_msg();
    run_seg(3, 12, 1'b0, 1'b1, 1'b0, "R6 short");

    // R7: tag compare
    new_msg();
    fill(6);
    m_tag = model_seg(128'd0, derive(m_key, 1), derive(m_key, 2), derive(m_key, 3), 2, 16, 1'b0);
    wr(1'b0, 3, m_tag[127:64]); wr(1'b0, 4, m_tag[63:0]);
    run_seg(2, 16, 1'b0, 1'b0, 1'b1, "R7 match");
    new_msg();
    m_tag = m_tag ^ (128'd1 << 77);
    wr(1'b0, 3, m_tag[127:64]);
    run_seg(2, 16, 1'b0, 1'b0, 1'b1, "R7 mismatch");
    new_msg();
    run_seg(1, 16, 1'b1, 1'b0, 1'b1, "R7 suspended no verdict");

    // R8: unused word
    wr(1'b0, 12, 64'hFFFF_0000_FFFF_0000);
    rd(12, w); chk("R8 word 12 reads zero", 128'(w), 128'd0);

    // R11: reset again clears context
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_pair(1, p); chk("R11 chain cleared", p, 128'd0);
    rd(11, w);     chk("R11 total length cleared", 128'(w), 128'd0);
    chk("R11 mac cleared", mac, 128'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule